// File: doc/BRIEF.md
# Low-Power PWM Timer

A single-channel pulse-width modulation timer controlled through a small register port. A power-of-two prescaler slows the system clock. It feeds a 16-bit up-counter that runs from zero to a programmed period value and then wraps. The output is active while the counter is above a programmed compare value, and a polarity bit can invert it.

Register writes are gated by the timer's enable state. The prescaler and polarity can be changed only while the timer is disabled. Period and compare values can be changed only while it is enabled. Each accepted period or compare write raises a sticky completion flag two clock cycles later, and software clears that flag through a write-one-to-clear register. A new period or compare value loaded while the counter runs takes effect at the next counter wrap, so a waveform period is never cut short.

The register port is plain control: each write is taken in the cycle it is presented, and there is no back-pressure. Reads are combinational from the address. Register map (address: content):
- 0, control: bit 0 enable, bit 1 start (read back as running)
- 1, configuration: bits 2:0 prescale exponent, bit 3 polarity
- 2, period
- 3, compare
- 4, status: bit 0 period done, bit 1 compare done
- 5, flag clear: bit 0 and bit 1, same positions as status

Top module: `lp_pwm_timer`

## Requirements
- R1: The counter advances once every 2^N clock cycles, where N is configuration bits 2:0 (0 to 7).
- R2: A write to configuration (address 1) is ignored while enable (control bit 0) is 1; the value read back is unchanged.
- R3: Writes to period (address 2) and compare (address 3) are ignored while enable is 0; the value read back is unchanged and no completion flag is raised.
- R4: An accepted period write sets status bit 0, and an accepted compare write sets status bit 1. The flag reads 0 after the write edge and the edge after it, and reads 1 after the second edge following the write. It then stays set.
- R5: Writing 1 to bit 0 or bit 1 of flag clear (address 5) clears the matching status bit. If a flag is being set in the same cycle, the set wins.
- R6: Once started, one output period lasts (P+1)·2^N cycles, and the active level lasts (P−C)·2^N cycles of it when C<P and 0 cycles otherwise, where P is the period value and C the compare value.
- R7: With configuration bit 3 at 0 the active level is 1. With it at 1 the whole waveform is inverted.
- R8: Writing control with bit 0 at 0 disables the timer, stops the counter and resets it to 0. The output then sits at its inactive level, and control reads 0.
- R9: Period and compare values written while running take effect at the next wrap. The steady waveform then follows the new values per R6.
- R10: A control write with bits 0 and 1 both set starts the counter only if enable was already 1. From the disabled state it only enables, and control reads 1 (running bit 1 stays 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System and counter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe, taken the same cycle |
| bus_addr | input | 3 | Register address for read and write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| pwm_out | output | 1 | PWM waveform |

## Verification
Two functions can fall in the same cycle: the delayed raising of a completion flag and a software write to flag clear. The bench times a clear write so that its edge matches the second edge after a compare write, when the flag is being raised. It judges the case correct if the flag reads 1 afterwards, and it then shows that a later clear takes the flag to 0. A second overlap is a compare or period update arriving mid-period. The bench lets the old period finish, then counts active cycles over a whole number of new periods. The count must match the new values exactly.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  localparam logic [2:0] ADDR_CTRL   = 3'd0;
  localparam logic [2:0] ADDR_CFG    = 3'd1;
  localparam logic [2:0] ADDR_PERIOD = 3'd2;
  localparam logic [2:0] ADDR_CMP    = 3'd3;
  localparam logic [2:0] ADDR_STATUS = 3'd4;
  localparam logic [2:0] ADDR_CLEAR  = 3'd5;

  localparam int CTRL_EN_BIT    = 0;
  localparam int CTRL_START_BIT = 1;
  localparam int FLAG_PRD_BIT   = 0;
  localparam int FLAG_CMP_BIT   = 1;
endpackage

// File: rtl/lpt_regfile.sv
module lpt_regfile
  import lpt_pkg::*;
#(
  parameter int DW   = 16,
  parameter int PW   = 3,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [2:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          en_o,
  output logic          run_o,
  output logic [PW-1:0] psc_o,
  output logic          pol_o,
  output logic [DW-1:0] prd_o,
  output logic [DW-1:0] cmp_o
);
  logic            en_q, run_q, pol_q;
  logic [PW-1:0]   psc_q;
  logic [DW-1:0]   prd_q, cmp_q;
  logic [SYNC-1:0] prd_pipe, cmp_pipe;
  logic            prd_done, cmp_done;

  logic wr_ctrl, wr_cfg, wr_prd, wr_cmp, wr_clr;
  logic prd_set, cmp_set;

  assign wr_ctrl = we && (addr == ADDR_CTRL);
  assign wr_cfg  = we && (addr == ADDR_CFG) && !en_q;
  assign wr_prd  = we && (addr == ADDR_PERIOD) && en_q;
  assign wr_cmp  = we && (addr == ADDR_CMP) && en_q;
  assign wr_clr  = we && (addr == ADDR_CLEAR);
  assign prd_set = prd_pipe[SYNC-1];
  assign cmp_set = cmp_pipe[SYNC-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      run_q <= 1'b0;
    end else if (wr_ctrl) begin
      en_q  <= wdata[CTRL_EN_BIT];
      run_q <= wdata[CTRL_EN_BIT] & (run_q | (wdata[CTRL_START_BIT] & en_q));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      psc_q <= '0;
      pol_q <= 1'b0;
    end else if (wr_cfg) begin
      psc_q <= wdata[PW-1:0];
      pol_q <= wdata[PW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prd_q <= '0;
      cmp_q <= '0;
    end else begin
      if (wr_prd) prd_q <= wdata;
      if (wr_cmp) cmp_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prd_pipe <= '0;
      cmp_pipe <= '0;
      prd_done <= 1'b0;
      cmp_done <= 1'b0;
    end else begin
      prd_pipe <= (prd_pipe << 1) | SYNC'(wr_prd);
      cmp_pipe <= (cmp_pipe << 1) | SYNC'(wr_cmp);
      prd_done <= prd_set | (prd_done & ~(wr_clr & wdata[FLAG_PRD_BIT]));
      cmp_done <= cmp_set | (cmp_done & ~(wr_clr & wdata[FLAG_CMP_BIT]));
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_CTRL:   rdata = DW'({run_q, en_q});
      ADDR_CFG:    rdata = DW'({pol_q, psc_q});
      ADDR_PERIOD: rdata = prd_q;
      ADDR_CMP:    rdata = cmp_q;
      ADDR_STATUS: rdata = DW'({cmp_done, prd_done});
      default:     rdata = '0;
    endcase
  end

  assign en_o  = en_q;
  assign run_o = run_q;
  assign psc_o = psc_q;
  assign pol_o = pol_q;
  assign prd_o = prd_q;
  assign cmp_o = cmp_q;

  // R2
  cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && we && addr == ADDR_CFG) |=> ($stable(psc_q) && $stable(pol_q)));
  // R3
  prd_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && we && addr == ADDR_PERIOD) |=> $stable(prd_q));
  // R4
  prd_flag_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prd_set |=> prd_done);
  // R4
  cmp_flag_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_set |=> cmp_done);
  // R5
  cmp_flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && wdata[FLAG_CMP_BIT] && !cmp_set) |=> !cmp_done);
  // R10
  run_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> en_q);
endmodule

// File: rtl/lpt_prescaler.sv
module lpt_prescaler #(
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic [PW-1:0] psc_i,
  output logic          tick_o
);
  localparam int PCW = (1 << PW) - 1;

  logic [PCW:0]   one_sh;
  logic [PCW-1:0] lim, pc_q;

  assign one_sh = {{PCW{1'b0}}, 1'b1} << psc_i;
  assign lim    = one_sh[PCW-1:0] - PCW'(1);
  assign tick_o = run_i && (pc_q == lim);

  always_ff @(posedge clk) begin
    if (!rst_n)        pc_q <= '0;
    else if (!run_i)   pc_q <= '0;
    else if (tick_o)   pc_q <= '0;
    else               pc_q <= pc_q + PCW'(1);
  end

  // R1
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && psc_i != '0) |=> !tick_o);
  // R8
  idle_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |-> !tick_o);
endmodule

// File: rtl/lpt_core.sv
module lpt_core #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic          pol_i,
  input  logic [DW-1:0] prd_i,
  input  logic [DW-1:0] cmp_i,
  output logic          pwm_o
);
  logic [DW-1:0] cnt_q, prd_act, cmp_act;
  logic          wrap;

  assign wrap = tick_i && (cnt_q == prd_act);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      prd_act <= '0;
      cmp_act <= '0;
    end else if (!run_i) begin
      cnt_q   <= '0;
      prd_act <= prd_i;
      cmp_act <= cmp_i;
    end else if (wrap) begin
      cnt_q   <= '0;
      prd_act <= prd_i;
      cmp_act <= cmp_i;
    end else if (tick_i) begin
      cnt_q   <= cnt_q + DW'(1);
    end
  end

  assign pwm_o = pol_i ^ (run_i && (cnt_q > cmp_act));

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q <= prd_act));
  // R8
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (cnt_q == '0));
  // R9
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && $past(run_i) && !$past(wrap)) |-> ($stable(prd_act) && $stable(cmp_act)));
endmodule

// File: rtl/lp_pwm_timer.sv
module lp_pwm_timer #(
  parameter int DW   = 16,
  parameter int PW   = 3,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [2:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          pwm_out
);
  logic          en, run, pol, tick;
  logic [PW-1:0] psc;
  logic [DW-1:0] prd, cmp;

  lpt_regfile #(.DW(DW), .PW(PW), .SYNC(SYNC)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .rdata(bus_rdata), .en_o(en), .run_o(run), .psc_o(psc), .pol_o(pol),
    .prd_o(prd), .cmp_o(cmp)
  );

  lpt_prescaler #(.PW(PW)) u_psc (
    .clk(clk), .rst_n(rst_n), .run_i(run), .psc_i(psc), .tick_o(tick)
  );

  lpt_core #(.DW(DW)) u_core (
    .clk(clk), .rst_n(rst_n), .run_i(run), .tick_i(tick), .pol_i(pol),
    .prd_i(prd), .cmp_i(cmp), .pwm_o(pwm_out)
  );

  // R8
  disabled_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (pwm_out == pol));
endmodule

// File: tb/lp_pwm_timer_tb.sv
module lp_pwm_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic        pwm_out;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  lp_pwm_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  always #5 clk = ~clk;

  function automatic int exp_active(int prd, int cmp, int n, int periods);
    int a;
    a = (cmp < prd) ? (prd - cmp) : 0;
    return (a << n) * periods;
  endfunction

  function automatic int win_len(int prd, int n, int periods);
    return ((prd + 1) << n) * periods;
  endfunction

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [15:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    peek(a, d);
  endtask

  task automatic measure(input int len, input logic pol, output int act);
    act = 0;
    for (int i = 0; i < len; i++) begin
      if (pwm_out !== pol) act++;
      @(negedge clk);
    end
  endtask

  task automatic start_cfg(int n, logic pol, int prd, int cmp);
    wr(3'd0, 16'h0000);
    wr(3'd1, 16'(n | (int'(pol) << 3)));
    wr(3'd0, 16'h0001);
    wr(3'd2, 16'(prd));
    wr(3'd3, 16'(cmp));
    wr(3'd0, 16'h0003);
  endtask

  task automatic run_case(string tag, int n, logic pol, int prd, int cmp);
    int act;
    start_cfg(n, pol, prd, cmp);
    measure(win_len(prd, n, 2), pol, act);
    chk(tag, act, exp_active(prd, cmp, n, 2));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    int act;
    void'($urandom(32'h5EED_0042));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    chk("reset pwm_out", int'(pwm_out), 0);
    rd(3'd0, d); chk("reset control", int'(d), 0);
    rd(3'd4, d); chk("reset status", int'(d), 0);

    // R3: period/compare writes while disabled are ignored
    wr(3'd2, 16'd5);
    wr(3'd3, 16'd2);
    rd(3'd2, d); chk("R3 period unchanged", int'(d), 0);
    rd(3'd3, d); chk("R3 compare unchanged", int'(d), 0);
    repeat (3) @(negedge clk);
    peek(3'd4, d); chk("R3 no flag", int'(d), 0);

    // R10: start from disabled only enables
    wr(3'd0, 16'h0003);
    rd(3'd0, d); chk("R10 control after start from disabled", int'(d), 1);

    // R2: configuration locked while enabled
    wr(3'd1, 16'h000A);
    rd(3'd1, d); chk("R2 cfg unchanged", int'(d), 0);

    // R4: flag timing of period write
    wr(3'd2, 16'd7);
    peek(3'd4, d); chk("R4 flag after write edge", int'(d[0]), 0);
    @(negedge clk);
    peek(3'd4, d); chk("R4 flag one edge later", int'(d[0]), 0);
    @(negedge clk);
    peek(3'd4, d); chk("R4 flag two edges later", int'(d[0]), 1);
    repeat (4) @(negedge clk);
    peek(3'd4, d); chk("R4 flag sticky", int'(d[0]), 1);

    // R5: clear coinciding with compare flag set: set wins
    wr(3'd3, 16'd2);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 3'd5; bus_wdata = 16'h0002;
    @(negedge clk);
    bus_we = 1'b0;
    peek(3'd4, d); chk("R5 set wins over clear", int'(d[1]), 1);
    wr(3'd5, 16'h0003);
    peek(3'd4, d); chk("R5 flags cleared", int'(d), 0);

    // R6 / R1 / R7 directed cases
    run_case("R6 n0 p9 c3", 0, 1'b0, 9, 3);
    run_case("R1 n2 p5 c1", 2, 1'b0, 5, 1);
    run_case("R7 inverted n2 p5 c1", 2, 1'b1, 5, 1);
    run_case("R6 compare equals period", 1, 1'b0, 4, 4);
    run_case("R1 max prescale n7 p1 c0", 7, 1'b0, 1, 0);
    rd(3'd0, d); chk("R10 control while running", int'(d), 3);

    // R8: disable with polarity 1
    start_cfg(1, 1'b1, 6, 2);
    repeat (9) @(negedge clk);
    wr(3'd0, 16'h0000);
    peek(3'd0, d); chk("R8 control reads 0", int'(d), 0);
    measure(40, 1'b1, act); chk("R8 idle at inactive level", act, 0);

    // random configurations, including updates while running (R9)
    for (int it = 0; it < 24; it++) begin
      int n, prd, cmp, prd2, cmp2;
      logic pol;
      n   = int'($urandom_range(0, 3));
      prd = int'($urandom_range(1, 20));
      cmp = int'($urandom_range(0, 22));
      pol = 1'($urandom_range(0, 1));
      run_case("R6 R7 random", n, pol, prd, cmp);
      prd2 = int'($urandom_range(1, 20));
      cmp2 = int'($urandom_range(0, 22));
      wr(3'd2, 16'(prd2));
      wr(3'd3, 16'(cmp2));
      repeat (((prd + 1) << n) + ((prd2 + 1) << n) + 4) @(negedge clk);
      measure(win_len(prd2, n, 2), pol, act);
      chk("R9 update while running", act, exp_active(prd2, cmp2, n, 2));
      peek(3'd4, d); chk("R4 flags after running update", int'(d), 3);
      wr(3'd5, 16'h0003);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule